// File: doc/BRIEF.md
# Half-Bridge Fault Supervisor and Output Gate

This block sits between a committed 16-bit command word and six half-bridge channels, each with a low-side and a high-side switch. It turns the programmed enables into twelve gate enables. It also applies the protection policy, which it takes from three mode bits in the same word. Its inputs are per-switch overcurrent and under-load indications, six over-temperature sensors, one thermal-warning input, and supply overvoltage and undervoltage indications.

Overcurrent and under-load must each stay present for a programmable number of clock cycles before they count. A qualified fault always raises a sticky flag. When the matching mode bit is set, it also latches the offending switch off until software resets it. Over-temperature, undervoltage and (when enabled) overvoltage remove all gates only while they last, and they leave the programmed selection untouched. The status word reports the sticky flags and the actual gate states. A reset bit in the command word clears the flags and the latch-offs.

Top module: `hbridge_fault_gate`

## Requirements
- R1: After synchronous reset, every gate enable is 0 and the status word reads 0.
- R2: On a commit, command bit i+1 (for i = 0..11) programs gate_en[i]. The even indices are channel low sides and the odd indices are channel high sides. Status bits 12:1 always equal gate_en[11:0].
- R3: An overcurrent input counts only after it has been high for OC_DLY consecutive cycles on a switch that is programmed on. The overload flag (status bit 13) then appears one cycle later and stays set. Shorter pulses leave the flag at 0.
- R4: With command bit 13 at 0, a qualified overcurrent sets the flag and the switch stays on.
- R5: With command bit 13 at 1, a qualified overcurrent forces that switch off and leaves the other switches alone. The switch stays off after the fault clears, until a status reset.
- R6: An under-load input qualifies after UL_DLY cycles and sets status bit 14. With command bit 14 at 1, it also latches the offending switch off until a status reset.
- R7: Overvoltage sets the sticky supply-fail flag (status bit 15). With command bit 15 at 1, all gates drop while overvoltage lasts and return to the programmed state afterwards. With bit 15 at 0, the gates are unaffected.
- R8: Undervoltage forces all gates off at once and sets the supply-fail flag.
- R9: Over-temperature on any of the six sensors forces all gates off. The programmed selection returns as soon as every sensor clears.
- R10: The thermal-warning flag (status bit 0) latches and stays set after the input clears, until a status reset.
- R11: A commit with command bit 0 set clears all sticky flags and latch-offs at that clock edge. A condition still present sets its flag again one cycle later.
- R12: The qualification count restarts when the fault input drops or the switch is programmed off.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_word | input | 16 | Command: bit 0 status reset, 12:1 switch enables, 13/14/15 overcurrent/under-load/overvoltage shutdown modes |
| cmd_commit | input | 1 | One-cycle strobe that takes cmd_word |
| oc_in | input | 12 | Overcurrent per switch, same index as gate_en |
| ul_in | input | 12 | Under-load per switch, same index as gate_en |
| ot_in | input | 6 | Over-temperature, one sensor per channel |
| tw_in | input | 1 | Thermal warning |
| ov_in | input | 1 | Supply overvoltage |
| uv_in | input | 1 | Supply undervoltage |
| gate_en | output | 12 | Gate enables to the switches |
| status_word | output | 16 | Bit 0 thermal warning, 12:1 gate states, 13 overload, 14 under-load, 15 supply fail |

## Verification
The assertions assume that the fault and supply inputs are already synchronous to clk and that cmd_commit is a clean single-cycle strobe. The bench therefore changes every input only on the falling edge and holds each commit for exactly one cycle. It also assumes that a commit with status reset is never issued during reset. Each sticky property excludes the reset-commit cycle, so the bench can issue resets while faults are still present. In that way it exercises the clear-then-set-again ordering.

// File: rtl/hbfg_pkg.sv
// Shared types for the half-bridge fault supervisor.
// Assumes: nothing; pure declarations.
package hbfg_pkg;
    // Sticky flag set, ordered as the status word places them (high to low).
    typedef struct packed {
        logic psf;  // supply fail
        logic ul;   // under-load
        logic oc;   // overload
        logic tw;   // thermal warning
    } flags_t;
endpackage

// File: rtl/hbfg_qual.sv
// Fault qualifier: asserts qual once flt has been high for DLY consecutive
// cycles while arm is high. The count restarts when either input drops.
// Assumes: flt is synchronous to clk; DLY >= 1.
module hbfg_qual #(
    parameter int DLY = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic arm,
    input  logic flt,
    output logic qual
);
    localparam int CW = $clog2(DLY + 1);
    localparam logic [CW-1:0] LIMIT = CW'(DLY);

    logic [CW-1:0] cnt;

    // Saturating persistence counter, cleared whenever the fault is not armed.
    always_ff @(posedge clk) begin
        if (!rst_n)             cnt <= '0;
        else if (!(arm && flt)) cnt <= '0;
        else if (cnt != LIMIT)  cnt <= cnt + 1'b1;
    end

    assign qual = (cnt == LIMIT);
endmodule

// File: rtl/hbfg_flags.sv
// Sticky flag register: bits accumulate until clr. clr wins over set in the
// same cycle, so a condition that persists reappears one cycle later.
// Assumes: set and clr are synchronous to clk.
module hbfg_flags
    import hbfg_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   clr,
    input  flags_t set,
    output flags_t q
);
    // Accumulate or clear the sticky flags.
    always_ff @(posedge clk) begin
        if (!rst_n)   q <= '0;
        else if (clr) q <= '0;
        else          q <= q | set;
    end
endmodule

// File: rtl/hbridge_fault_gate.sv
// Top: command register, per-switch fault qualification and latch-off,
// global transient shutdowns and status assembly.
// Assumes: all inputs synchronous to clk; cmd_commit is a one-cycle strobe.
module hbridge_fault_gate
    import hbfg_pkg::*;
#(
    parameter int NUM_CH = 6,
    parameter int OC_DLY = 4,
    parameter int UL_DLY = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [2*NUM_CH+3:0]   cmd_word,
    input  logic                  cmd_commit,
    input  logic [2*NUM_CH-1:0]   oc_in,
    input  logic [2*NUM_CH-1:0]   ul_in,
    input  logic [NUM_CH-1:0]     ot_in,
    input  logic                  tw_in,
    input  logic                  ov_in,
    input  logic                  uv_in,
    output logic [2*NUM_CH-1:0]   gate_en,
    output logic [2*NUM_CH+3:0]   status_word
);
    localparam int NOUT   = 2 * NUM_CH;
    localparam int W      = NOUT + 4;
    localparam int OCSD_B = NOUT + 1;
    localparam int ULSD_B = NOUT + 2;
    localparam int OVSD_B = NOUT + 3;

    logic [W-1:1]    cmd_q;
    logic            srr;
    logic [NOUT-1:0] prog_en;
    logic [NOUT-1:0] oc_qual;
    logic [NOUT-1:0] ul_qual;
    logic [NOUT-1:0] latch_off;
    logic            global_off;
    flags_t          flag_set;
    flags_t          flag_q;

    assign srr     = cmd_commit && cmd_word[0];
    assign prog_en = cmd_q[NOUT:1];

    // Command register: holds enables and mode bits; bit 0 acts as a pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)          cmd_q <= '0;
        else if (cmd_commit) cmd_q <= cmd_word[W-1:1];
    end

    // One overcurrent and one under-load qualifier per switch.
    for (genvar i = 0; i < NOUT; i++) begin : g_sw
        hbfg_qual #(.DLY(OC_DLY)) u_oc (
            .clk(clk), .rst_n(rst_n), .arm(prog_en[i]),
            .flt(oc_in[i]), .qual(oc_qual[i])
        );
        hbfg_qual #(.DLY(UL_DLY)) u_ul (
            .clk(clk), .rst_n(rst_n), .arm(prog_en[i]),
            .flt(ul_in[i]), .qual(ul_qual[i])
        );
    end

    // Per-switch latch-off, applied per the mode bits, cleared by status reset.
    always_ff @(posedge clk) begin
        if (!rst_n)   latch_off <= '0;
        else if (srr) latch_off <= '0;
        else          latch_off <= latch_off
                                 | (oc_qual & {NOUT{cmd_q[OCSD_B]}})
                                 | (ul_qual & {NOUT{cmd_q[ULSD_B]}});
    end

    // Transient conditions that remove every gate while present.
    assign global_off = (|ot_in) || uv_in || (ov_in && cmd_q[OVSD_B]);

    // Gate enables: programmed selection minus latched-off switches.
    always_comb begin
        gate_en = global_off ? '0 : (prog_en & ~latch_off);
    end

    // Conditions feeding the sticky flags.
    always_comb begin
        flag_set.tw  = tw_in;
        flag_set.oc  = |oc_qual;
        flag_set.ul  = |ul_qual;
        flag_set.psf = ov_in || uv_in;
    end

    hbfg_flags u_flags (
        .clk(clk), .rst_n(rst_n), .clr(srr), .set(flag_set), .q(flag_q)
    );

    assign status_word = {flag_q.psf, flag_q.ul, flag_q.oc, gate_en, flag_q.tw};
endmodule

// File: rtl/hbfg_chk.sv
// Checker for hbridge_fault_gate, attached by bind below.
// Assumes: inputs synchronous to clk.
module hbfg_chk #(
    parameter int NUM_CH = 6
) (
    input logic                clk,
    input logic                rst_n,
    input logic [2*NUM_CH+3:0] cmd_word,
    input logic                cmd_commit,
    input logic [NUM_CH-1:0]   ot_in,
    input logic                tw_in,
    input logic                ov_in,
    input logic                uv_in,
    input logic [2*NUM_CH-1:0] gate_en,
    input logic [2*NUM_CH+3:0] status_word
);
    localparam int NOUT = 2 * NUM_CH;
    logic srr_c;
    assign srr_c = cmd_commit && cmd_word[0];

    AST_UV_ALL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        uv_in |-> gate_en == '0); // R8
    AST_OT_ALL_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (|ot_in) |-> gate_en == '0); // R9
    AST_PSF_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        ((ov_in || uv_in) && !srr_c) |=> status_word[NOUT+3]); // R7
    AST_TW_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (status_word[0] && !srr_c) |=> status_word[0]); // R10
    AST_OC_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (status_word[NOUT+1] && !srr_c) |=> status_word[NOUT+1]); // R3
    AST_UL_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (status_word[NOUT+2] && !srr_c) |=> status_word[NOUT+2]); // R6
    AST_SRR_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        srr_c |=> (status_word[NOUT+3:NOUT+1] == 3'b000 && !status_word[0])); // R11
endmodule

bind hbridge_fault_gate hbfg_chk #(.NUM_CH(NUM_CH)) u_chk (
    .clk(clk), .rst_n(rst_n), .cmd_word(cmd_word), .cmd_commit(cmd_commit),
    .ot_in(ot_in), .tw_in(tw_in), .ov_in(ov_in), .uv_in(uv_in),
    .gate_en(gate_en), .status_word(status_word)
);

// File: tb/hbridge_fault_gate_tb.sv
module hbridge_fault_gate_tb;
    localparam int OC_D = 4;
    localparam int UL_D = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] cmd_word = '0;
    logic        cmd_commit = 1'b0;
    logic [11:0] oc_in = '0;
    logic [11:0] ul_in = '0;
    logic [5:0]  ot_in = '0;
    logic        tw_in = 1'b0;
    logic        ov_in = 1'b0;
    logic        uv_in = 1'b0;
    logic [11:0] gate_en;
    logic [15:0] status_word;

    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    hbridge_fault_gate #(.NUM_CH(6), .OC_DLY(OC_D), .UL_DLY(UL_D)) u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_word(cmd_word), .cmd_commit(cmd_commit),
        .oc_in(oc_in), .ul_in(ul_in), .ot_in(ot_in), .tw_in(tw_in),
        .ov_in(ov_in), .uv_in(uv_in), .gate_en(gate_en), .status_word(status_word)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic commit(input logic [15:0] w);
        cmd_word = w; cmd_commit = 1'b1;
        @(negedge clk);
        cmd_commit = 1'b0;
    endtask

    task automatic t_reset();
        step(3); rst_n = 1'b1; step(1);
        chk("R1 gates after reset", gate_en, 0);
        chk("R1 status after reset", status_word, 0);
    endtask

    task automatic t_map();
        commit(16'h0002); chk("R2 L1 -> gate0", gate_en, 12'h001);
        commit(16'h1000); chk("R2 H6 -> gate11", gate_en, 12'h800);
        commit(16'h1FFE); chk("R2 status mirrors gates", status_word, 16'h1FFE);
        commit(16'h0000);
    endtask

    task automatic t_oc_flag_only();
        commit(16'h0008);
        oc_in[2] = 1'b1;
        step(OC_D); chk("R3 no flag before delay", status_word[13], 0);
        step(1);    chk("R3 flag after delay", status_word[13], 1);
        chk("R4 switch stays on", gate_en, 12'h004);
        oc_in[2] = 1'b0; step(2);
        chk("R3 flag sticky", status_word[13], 1);
        commit(16'h0009); chk("R11 srr clears overload", status_word[13], 0);
    endtask

    task automatic t_oc_short();
        commit(16'h0008);
        oc_in[2] = 1'b1; step(OC_D - 1);
        oc_in[2] = 1'b0; step(1);
        oc_in[2] = 1'b1; step(OC_D - 1);
        oc_in[2] = 1'b0; step(2);
        chk("R3 short pulses ignored", status_word[13], 0);
    endtask

    task automatic t_oc_latch();
        commit(16'h2018);
        oc_in[3] = 1'b1; step(OC_D + 1);
        chk("R5 offending switch off", gate_en, 12'h004);
        oc_in[3] = 1'b0; step(3);
        chk("R5 stays off after fault clears", gate_en, 12'h004);
        commit(16'h2019);
        chk("R5 srr releases switch", gate_en, 12'h00C);
    endtask

    task automatic t_ul();
        commit(16'h4040);
        ul_in[5] = 1'b1; step(UL_D);
        chk("R6 no flag before delay", status_word[14], 0);
        chk("R6 on before delay", gate_en, 12'h020);
        step(1);
        chk("R6 under-load flag", status_word[14], 1);
        chk("R6 latch off", gate_en, 12'h000);
        commit(16'h4041);
        chk("R11 cleared at srr edge", status_word[14], 0);
        step(1);
        chk("R11 flag set again", status_word[14], 1);
        chk("R11 latch again", gate_en, 12'h000);
        ul_in[5] = 1'b0; commit(16'h4041); step(1);
        chk("R6 cleared when gone", status_word[14], 0);
    endtask

    task automatic t_restart();
        commit(16'h0002);
        oc_in[0] = 1'b1; step(OC_D - 2);
        commit(16'h0000);
        commit(16'h0002);
        step(OC_D - 1);
        chk("R12 count restarted", status_word[13], 0);
        step(2);
        chk("R12 qualifies after full window", status_word[13], 1);
        oc_in[0] = 1'b0; commit(16'h0001);
    endtask

    task automatic t_ov();
        commit(16'h0006);
        ov_in = 1'b1; #1;
        chk("R7 lockout off keeps gates", gate_en, 12'h003);
        step(1); chk("R7 supply fail flag", status_word[15], 1);
        ov_in = 1'b0; commit(16'h0007);
        commit(16'h8006);
        ov_in = 1'b1; #1;
        chk("R7 lockout drops gates", gate_en, 12'h000);
        step(2); chk("R7 still off", gate_en, 12'h000);
        ov_in = 1'b0; #1;
        chk("R7 gates return", gate_en, 12'h003);
        chk("R7 flag sticky", status_word[15], 1);
        commit(16'h0007);
    endtask

    task automatic t_uv();
        commit(16'h0006);
        uv_in = 1'b1; #1;
        chk("R8 undervoltage off", gate_en, 12'h000);
        step(1); chk("R8 supply fail", status_word[15], 1);
        uv_in = 1'b0; #1;
        chk("R8 gates back", gate_en, 12'h003);
        commit(16'h0007);
    endtask

    task automatic t_ot();
        ot_in = 6'b001000; #1;
        chk("R9 over-temp all off", gate_en, 12'h000);
        step(2);
        ot_in = 6'b000000; #1;
        chk("R9 selection resumes", status_word[12:1], 12'h003);
    endtask

    task automatic t_tw();
        tw_in = 1'b1; step(1);
        chk("R10 warning set", status_word[0], 1);
        tw_in = 1'b0; step(3);
        chk("R10 warning held", status_word[0], 1);
        commit(16'h0001);
        chk("R10 srr clears warning", status_word[0], 0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        t_reset();
        t_map();
        t_oc_flag_only();
        t_oc_short();
        t_oc_latch();
        t_ul();
        t_restart();
        t_ov();
        t_uv();
        t_ot();
        t_tw();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule